// File: doc/BRIEF.md
# Priority interrupt CPU interface

This block sits between an interrupt distributor and one processor. Each cycle it looks at every source that is both enabled and pending, picks the one with the numerically smallest priority (the smallest source number breaks a tie), and raises the processor interrupt line when that winner may preempt whatever is running now. The processor claims an interrupt by reading the acknowledge register and signals the end of handling by writing the interrupt's ID to the end-of-interrupt register.

Nesting is tracked by a per-source predecessor table. Each successful acknowledge links the new interrupt to the one it preempted. Ending the running interrupt restores its predecessor. Ending an interrupt that sits deeper in the nest unlinks it from the table through a short multi-cycle walk, and the bus is held off with `ready_o` low until the walk is done. Pending bits live in the distributor. The block asks for them to be cleared or set through one-cycle strobes.

Top module: `prio_cpu_if`

## Requirements
- R1: After reset the interface is disabled, the mask reads 0xF0, the running priority reads 0x100, the highest-pending register and an acknowledge read both return 1023 (no interrupt), and `irq_o` is low.
- R2: Among sources with enable and pending both set, the highest-pending register (offset 0x18) reports the one with the smallest priority value, and the smallest source number among equals.
- R3: `irq_o` is low, and offset 0x18 reads 1023, while `dist_en_i` is low or control bit 0 (offset 0x00) is clear.
- R4: A winner whose priority value is greater than the mask (offset 0x04) does not raise `irq_o` and reads as 1023. A priority equal to the mask is allowed.
- R5: `irq_o` is high only while the winner's priority value is strictly below the running priority.
- R6: An acknowledge read (offset 0x0C) with no eligible winner, or with a winner not below the running priority, returns 1023 and changes no state.
- R7: A successful acknowledge returns the winner's ID, pulses `pend_clr_o` for that source only during the read cycle, makes the winner the running interrupt with its priority, and records the previously running ID as its predecessor.
- R8: An end-of-interrupt write (offset 0x10, ID in bits 9:0) naming the running ID completes without stall and makes the predecessor running, with the predecessor's current priority, or with 1023 and 0x100 when there is none.
- R9: An end-of-interrupt write while the running ID is 1023 completes at once and changes nothing, and no `pend_set_o` strobe is issued.
- R10: An end-of-interrupt write naming a non-running ID holds `ready_o` low while the chain is walked from the running ID. The ID is unlinked if found, and the running ID and priority do not change.
- R11: When an end-of-interrupt write completes while an interrupt is running, and the named source is level-triggered (`src_edge_i` bit 0), enabled, and its line is high, `pend_set_o` pulses for that source in the completing cycle.
- R12: Offset 0x00 holds the interface enable in bit 0, offset 0x04 holds the 8-bit mask, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_en_i | input | 1 | Global distributor enable |
| src_en_i | input | NUM_SRC | Per-source enable |
| src_pend_i | input | NUM_SRC | Per-source pending |
| src_edge_i | input | NUM_SRC | Per-source trigger type, 1 = edge, 0 = level |
| src_level_i | input | NUM_SRC | Per-source input line level |
| src_prio_i | input | NUM_SRC*PRIO_W | Packed priorities, source i at bits [i*PRIO_W +: PRIO_W] |
| irq_o | output | 1 | Processor interrupt request |
| pend_clr_o | output | NUM_SRC | One-cycle pending-clear strobes |
| pend_set_o | output | NUM_SRC | One-cycle pending-set strobes |
| req_i | input | 1 | Bus request, held until ready_o |
| we_i | input | 1 | Bus write enable |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Transfer completes in a cycle with req_i and ready_o both high |
| rdata_o | output | DATA_W | Read data, valid with ready_o |

## Verification
The hardest state to reach is a three-deep nest where the end-of-interrupt names the middle entry. That is the only case where the walk changes a link rather than the running state. The bench builds it by raising sources with falling priority values one at a time and acknowledging each, then ends the middle one and counts the stall cycles. A later end of the top entry must then land on the bottom one, which shows the link was rewritten. The middle source is level-triggered with its line held high, so the same completion also covers the re-pend strobe.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int ID_W      = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;
  localparam int RPRIO_W   = 9;
  localparam logic [RPRIO_W-1:0] IDLE_PRIO = 9'h100;

  // word indices of the register map
  localparam int W_CTRL = 0;
  localparam int W_MASK = 1;
  localparam int W_ACK  = 3;
  localparam int W_EOI  = 4;
  localparam int W_RUNP = 5;
  localparam int W_HPID = 6;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_STEP = 2'd1,
    WK_DONE = 2'd2
  } walk_st_e;
endpackage

// File: rtl/prio_arbiter.sv
module prio_arbiter
  import prio_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = NO_IRQ;
    prio_o  = '1;
    // ascending scan with strict compare keeps the lowest ID on ties
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_chain.sv
module prio_chain
  import prio_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic                      push_i,
  input  logic [ID_W-1:0]           push_id_i,
  input  logic [PRIO_W-1:0]         push_prio_i,
  input  logic                      eoi_req_i,
  input  logic [ID_W-1:0]           eoi_id_i,
  output logic [ID_W-1:0]           run_id_o,
  output logic [RPRIO_W-1:0]        run_prio_o,
  output logic                      eoi_ack_o,
  output logic                      walk_busy_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [ID_W-1:0]    pred_q [NUM_SRC];
  logic [ID_W-1:0]    run_id_q, cur_q, tgt_q;
  logic [RPRIO_W-1:0] run_prio_q;
  walk_st_e           st_q;
  logic [PRIO_W-1:0]  prio_a [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    assign prio_a[g] = src_prio_i[g*PRIO_W +: PRIO_W];
  end

  function automatic logic [RPRIO_W-1:0] prio_of(input logic [ID_W-1:0] id);
    if (id >= ID_W'(NUM_SRC)) return IDLE_PRIO;
    return {1'b0, prio_a[id[IDX_W-1:0]]};
  endfunction

  logic run_valid, hits_run, idle, pop, start;
  logic [ID_W-1:0] pop_id, nxt_id, tgt_pred;

  assign run_valid = run_id_q != NO_IRQ;
  assign hits_run  = eoi_id_i == run_id_q;
  assign idle      = st_q == WK_IDLE;
  assign pop       = idle && eoi_req_i && run_valid && hits_run;
  assign start     = idle && eoi_req_i && run_valid && !hits_run;
  assign pop_id    = pred_q[run_id_q[IDX_W-1:0]];
  assign nxt_id    = pred_q[cur_q[IDX_W-1:0]];
  assign tgt_pred  = (tgt_q < ID_W'(NUM_SRC)) ? pred_q[tgt_q[IDX_W-1:0]] : NO_IRQ;

  assign eoi_ack_o   = (idle && eoi_req_i && (!run_valid || hits_run)) || (st_q == WK_DONE);
  assign walk_busy_o = st_q == WK_STEP;
  assign run_id_o    = run_id_q;
  assign run_prio_o  = run_prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SRC; i++) pred_q[i] <= NO_IRQ;
      run_id_q   <= NO_IRQ;
      run_prio_q <= IDLE_PRIO;
      cur_q      <= NO_IRQ;
      tgt_q      <= NO_IRQ;
      st_q       <= WK_IDLE;
    end else begin
      if (push_i) begin
        pred_q[push_id_i[IDX_W-1:0]] <= run_id_q;
        run_id_q   <= push_id_i;
        run_prio_q <= {1'b0, push_prio_i};
      end else if (pop) begin
        run_id_q   <= pop_id;
        run_prio_q <= prio_of(pop_id);
      end
      unique case (st_q)
        WK_IDLE: if (start) begin
          st_q  <= WK_STEP;
          cur_q <= run_id_q;
          tgt_q <= eoi_id_i;
        end
        WK_STEP: begin
          if (nxt_id == NO_IRQ) begin
            st_q <= WK_DONE;
          end else if (nxt_id == tgt_q) begin
            pred_q[cur_q[IDX_W-1:0]] <= tgt_pred;
            st_q <= WK_DONE;
          end else begin
            cur_q <= nxt_id;
          end
        end
        WK_DONE: st_q <= WK_IDLE;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  AST_IDLE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_id_q == NO_IRQ) |-> (run_prio_q == IDLE_PRIO)); // R8
  AST_WALK_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WK_STEP) |-> run_valid); // R10
  AST_WALK_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WK_STEP) |=> $stable(run_id_q)); // R10
endmodule

// File: rtl/prio_cpu_if.sv
module prio_cpu_if
  import prio_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int PRIO_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [PRIO_W-1:0] MASK_RST = 8'hF0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dist_en_i,
  input  logic [NUM_SRC-1:0]        src_en_i,
  input  logic [NUM_SRC-1:0]        src_pend_i,
  input  logic [NUM_SRC-1:0]        src_edge_i,
  input  logic [NUM_SRC-1:0]        src_level_i,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  output logic                      irq_o,
  output logic [NUM_SRC-1:0]        pend_clr_o,
  output logic [NUM_SRC-1:0]        pend_set_o,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic                      ready_o,
  output logic [DATA_W-1:0]         rdata_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic              cpu_en_q;
  logic [PRIO_W-1:0] mask_q;

  logic              best_valid;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   run_id;
  logic [RPRIO_W-1:0] run_prio;
  logic              eoi_ack, walk_busy;

  logic [WORD_W-1:0] word;
  logic hp_ok, preempt, ack_hit, eoi_hit, push, wr, eoi_done;
  logic [ID_W-1:0] hp_id, eoi_id;

  prio_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .cand_i  (src_en_i & src_pend_i),
    .prio_i  (src_prio_i),
    .valid_o (best_valid),
    .id_o    (best_id),
    .prio_o  (best_prio)
  );

  assign word    = addr_i[ADDR_W-1:2];
  assign hp_ok   = dist_en_i && cpu_en_q && best_valid && (best_prio <= mask_q);
  assign hp_id   = hp_ok ? best_id : NO_IRQ;
  assign preempt = hp_ok && ({1'b0, best_prio} < run_prio);
  assign irq_o   = preempt;

  assign ack_hit = req_i && !we_i && (word == WORD_W'(W_ACK));
  assign eoi_hit = req_i && we_i && (word == WORD_W'(W_EOI));
  assign push    = ack_hit && preempt;
  assign eoi_id  = wdata_i[ID_W-1:0];

  prio_chain #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_prio_i  (src_prio_i),
    .push_i      (push),
    .push_id_i   (best_id),
    .push_prio_i (best_prio),
    .eoi_req_i   (eoi_hit),
    .eoi_id_i    (eoi_id),
    .run_id_o    (run_id),
    .run_prio_o  (run_prio),
    .eoi_ack_o   (eoi_ack),
    .walk_busy_o (walk_busy)
  );

  assign ready_o  = eoi_hit ? eoi_ack : 1'b1;
  assign wr       = req_i && we_i && ready_o;
  assign eoi_done = eoi_hit && eoi_ack && (run_id != NO_IRQ);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_strobe
    assign pend_clr_o[g] = push && (best_id == ID_W'(g));
    assign pend_set_o[g] = eoi_done && (eoi_id == ID_W'(g)) && !src_edge_i[g]
                           && src_en_i[g] && src_level_i[g];
  end

  always_comb begin
    rdata_o = '0;
    unique case (word)
      WORD_W'(W_CTRL): rdata_o = DATA_W'(cpu_en_q);
      WORD_W'(W_MASK): rdata_o = DATA_W'(mask_q);
      WORD_W'(W_ACK):  rdata_o = DATA_W'(preempt ? best_id : NO_IRQ);
      WORD_W'(W_RUNP): rdata_o = DATA_W'(run_prio);
      WORD_W'(W_HPID): rdata_o = DATA_W'(hp_id);
      default:         rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_q <= 1'b0;
      mask_q   <= MASK_RST;
    end else if (wr) begin
      if (word == WORD_W'(W_CTRL)) cpu_en_q <= wdata_i[0];
      if (word == WORD_W'(W_MASK)) mask_q   <= wdata_i[PRIO_W-1:0];
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dist_en_i || !cpu_en_q) |-> !irq_o); // R3
  AST_IRQ_BELOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ({1'b0, best_prio} < run_prio)); // R5
  AST_ACK_TAKES_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> (run_id == $past(best_id))); // R7
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_clr_o)); // R7
  AST_SET_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_set_o)); // R11
  AST_WALK_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_busy |-> !ready_o); // R10
endmodule

// File: tb/prio_cpu_if_bench.sv
module prio_cpu_if_bench;
  localparam int N = 8;
  localparam int NV = 6;
  // {en, pend, prio[63:0], expected hp id, expected irq}
  localparam logic [90:0] VEC [NV] = '{
    {8'hFF, 8'h00, 64'hA0A0A0A0A0A0A0A0, 10'h3FF, 1'b0},
    {8'hFF, 8'h24, 64'hA0A020A0A040A0A0, 10'd5,   1'b1},
    {8'hFF, 8'h24, 64'hA0A030A0A030A0A0, 10'd2,   1'b1},
    {8'hDF, 8'h24, 64'hA0A010A0A080A0A0, 10'd2,   1'b1},
    {8'hFF, 8'h80, 64'hF8A0A0A0A0A0A0A0, 10'h3FF, 1'b0},
    {8'hFF, 8'h80, 64'hF0A0A0A0A0A0A0A0, 10'd7,   1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic dist_en = 1;
  logic [N-1:0] en = '1, pend_q = '0, edge_t = '1, level = '0;
  logic [N*8-1:0] prio = {N{8'hA0}};
  logic irq;
  logic [N-1:0] pend_clr, pend_set;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic ready;
  logic load_en = 0;
  logic [N-1:0] load_val = '0;
  logic [N-1:0] cap_set, cap_clr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  prio_cpu_if #(.NUM_SRC(N)) u_prio_cpu_if (
    .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en), .src_en_i(en),
    .src_pend_i(pend_q), .src_edge_i(edge_t), .src_level_i(level),
    .src_prio_i(prio), .irq_o(irq), .pend_clr_o(pend_clr),
    .pend_set_o(pend_set), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata)
  );

  // distributor model for the pending bits
  always @(posedge clk)
    if (load_en) pend_q <= load_val;
    else         pend_q <= (pend_q & ~pend_clr) | pend_set;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_pend(input logic [N-1:0] v);
    @(negedge clk); load_val = v; load_en = 1;
    @(negedge clk); load_en = 0;
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int stalls);
    @(negedge clk); req = 1; we = w; addr = a; wdata = d; stalls = 0;
    #2;
    while (!ready) begin
      stalls++;
      @(negedge clk); #2;
    end
    rd = rdata; cap_set = pend_set; cap_clr = pend_clr;
    @(posedge clk); #1; req = 0; we = 0;
  endtask

  task automatic see_irq(input string tag, input logic exp);
    @(negedge clk); #2;
    chk(tag, 32'(irq), 32'(exp));
  endtask

  logic [31:0] rd;
  int st;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    see_irq("R1 irq after reset", 1'b0);
    bus(0, 8'h00, 0, rd, st); chk("R1 ctrl reset", rd, 0);
    bus(0, 8'h04, 0, rd, st); chk("R1 mask reset", rd, 32'hF0);
    bus(0, 8'h14, 0, rd, st); chk("R1 running prio reset", rd, 32'h100);
    bus(0, 8'h18, 0, rd, st); chk("R1 hp id reset", rd, 32'h3FF);
    bus(0, 8'h0C, 0, rd, st); chk("R1 ack reset", rd, 32'h3FF);
    // R12 register access
    bus(1, 8'h00, 32'h1, rd, st);
    bus(0, 8'h00, 0, rd, st); chk("R12 ctrl readback", rd, 1);
    bus(1, 8'h04, 32'hC0, rd, st);
    bus(0, 8'h04, 0, rd, st); chk("R12 mask readback", rd, 32'hC0);
    bus(1, 8'h04, 32'hF0, rd, st);
    bus(0, 8'h08, 0, rd, st); chk("R12 unmapped read", rd, 0);

    // R2 / R4 arbitration table
    for (int i = 0; i < NV; i++) begin
      en = VEC[i][90:83]; prio = VEC[i][74:11];
      set_pend(VEC[i][82:75]);
      bus(0, 8'h18, 0, rd, st);
      chk($sformatf("R2/R4 vec%0d hp id", i), rd, 32'(VEC[i][10:1]));
      see_irq($sformatf("R4/R5 vec%0d irq", i), VEC[i][0]);
    end

    // R3 gating
    en = '1; prio = 64'hA0A020A0A040A0A0;
    set_pend(8'h04);
    see_irq("R3 baseline irq", 1'b1);
    dist_en = 0;
    see_irq("R3 dist off irq", 1'b0);
    bus(0, 8'h18, 0, rd, st); chk("R3 dist off hp id", rd, 32'h3FF);
    dist_en = 1;
    bus(1, 8'h00, 32'h0, rd, st);
    see_irq("R3 cpu off irq", 1'b0);
    bus(1, 8'h00, 32'h1, rd, st);
    set_pend(8'h00);

    // nesting: src1=0x80, src3=0x40 level, src6=0x20
    prio = 64'hA020A0A040A080A0; edge_t = 8'hF7; level = 8'h08;
    set_pend(8'h02);
    see_irq("R5 first irq", 1'b1);
    bus(0, 8'h0C, 0, rd, st); chk("R7 ack id 1", rd, 1);
    chk("R7 clear strobe", 32'(cap_clr), 32'h02);
    see_irq("R7 irq after ack", 1'b0);
    chk("R7 strobe one cycle", 32'(pend_clr), 0);
    bus(0, 8'h14, 0, rd, st); chk("R7 running prio 1", rd, 32'h80);
    set_pend(8'h08);
    bus(0, 8'h0C, 0, rd, st); chk("R7 ack id 3", rd, 3);
    set_pend(8'h40);
    bus(0, 8'h0C, 0, rd, st); chk("R7 ack id 6", rd, 6);
    bus(0, 8'h14, 0, rd, st); chk("R7 running prio 6", rd, 32'h20);
    // R6 no preemption
    set_pend(8'h02);
    see_irq("R5 no preempt irq", 1'b0);
    bus(0, 8'h0C, 0, rd, st); chk("R6 ack refused", rd, 32'h3FF);
    bus(0, 8'h14, 0, rd, st); chk("R6 running unchanged", rd, 32'h20);
    bus(0, 8'h18, 0, rd, st); chk("R6 pending kept", rd, 1);
    set_pend(8'h00);

    // R10 unlink middle entry, R11 re-pend of level source
    bus(1, 8'h10, 32'd3, rd, st);
    chk("R10 walk stalls", 32'(st > 0), 1);
    chk("R11 re-pend strobe", 32'(cap_set), 32'h08);
    bus(0, 8'h14, 0, rd, st); chk("R10 running kept", rd, 32'h20);
    set_pend(8'h00);
    bus(1, 8'h10, 32'd6, rd, st);
    chk("R8 running eoi no stall", 32'(st), 0);
    chk("R11 edge source no strobe", 32'(cap_set), 0);
    bus(0, 8'h14, 0, rd, st); chk("R8 predecessor is 1", rd, 32'h80);
    bus(1, 8'h10, 32'd5, rd, st);
    chk("R10 absent id walk stalls", 32'(st), 2);
    bus(0, 8'h14, 0, rd, st); chk("R10 absent id no change", rd, 32'h80);
    set_pend(8'h08);
    see_irq("R5 preempt running 1", 1'b1);
    set_pend(8'h00);
    bus(1, 8'h10, 32'd1, rd, st);
    bus(0, 8'h14, 0, rd, st); chk("R8 chain empty", rd, 32'h100);
    // R9 eoi with nothing running
    edge_t[1] = 0; level[1] = 1;
    bus(1, 8'h10, 32'd1, rd, st);
    chk("R9 no stall", 32'(st), 0);
    chk("R9 no strobe", 32'(cap_set), 0);
    bus(0, 8'h14, 0, rd, st); chk("R9 running unchanged", rd, 32'h100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule